// File: doc/BRIEF.md
# Timer Interrupt Status and Delivery Unit

This unit sits between a bank of timer channels and the rest of the chip. It turns per-channel fire events into interrupts. For each channel it keeps a sticky status bit and applies the channel's configuration. A channel's interrupt can take one of three forms: a level line, a one-cycle edge pulse, or a posted message write. The message write goes out on a valid/ready request port, and its address and data come from the channel's 64-bit route word.

Status is latched for level-type channels even while the channel is switched off. Turning the channel enable or the global enable back on then delivers the interrupt again. Software clears status by writing ones through a write-one-to-clear strobe. Message requests are collected in a pending bit per channel. An output slot is loaded from the lowest-numbered pending channel whenever the slot is empty or is being accepted in the same cycle.

Back-pressure rules for the message port are as follows. Once `msg_valid_o` rises, it stays high and `msg_addr_o`/`msg_data_o` stay stable until a cycle with `msg_ready_i` high. A new event on a channel that is already pending adds no second request. The route word of a pending channel must be held stable until its request has been accepted.

Top module: `tmr_irq_unit`

## Requirements
- R1: A fire on a channel whose trigger input is 1 (level) sets its status bit, and `status_o` shows it after the next clock edge, whatever the channel enable is.
- R2: A fire on a channel whose trigger input is 0 (edge) never sets its status bit. With the channel active and messaging off, `irq_o` of that channel is high for exactly the one cycle after the edge.
- R3: A channel is active only while its channel enable and the global enable are both 1. An inactive channel drives `irq_o` low and issues no message request.
- R4: For an active level channel with messaging off, `irq_o` equals the status bit, rising in the cycle after the fire edge.
- R5: With messaging on, a fire raises no line. Two edges after the fire edge, `msg_valid_o` is high with `msg_data_o` set to route bits [31:0] and `msg_addr_o` set to route bits [63:32].
- R6: While `msg_valid_o` is high and `msg_ready_i` is low, valid, address and data hold their values.
- R7: A fire on a channel that is already pending merges into the pending request, so exactly one message results.
- R8: With `clr_we_i` high, a 1 in `clr_data_i` clears that status bit and lowers the level line after the edge. A 0 leaves the bit unchanged. A level fire in the same cycle wins over the clear.
- R9: When a channel enable goes from 0 to 1 while the status bit is set, the interrupt is delivered again, as a line or as one message.
- R10: When the global enable goes from 0 to 1, every enabled channel with status set delivers its interrupt again.
- R11: When the trigger input goes from 1 to 0, the level line drops at once and the status bit is cleared at the next edge.
- R12: If several channels are pending, the lowest-numbered one is issued first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fire_i | input | NCH | Per-channel fire event, one cycle per event |
| lvl_i | input | NCH | Trigger type per channel, 1 level, 0 edge |
| ch_en_i | input | NCH | Per-channel interrupt enable |
| msg_en_i | input | NCH | Per-channel message-write routing enable |
| glb_en_i | input | 1 | Global interrupt enable |
| route_i | input | NCH*(AW+DW) | Route word per channel: data in the low DW bits, address above |
| clr_we_i | input | 1 | Status write strobe |
| clr_data_i | input | NCH | Write-one-to-clear mask |
| status_o | output | NCH | Status bits |
| irq_o | output | NCH | Interrupt lines |
| msg_valid_o | output | 1 | Message request valid |
| msg_addr_o | output | AW | Message write address |
| msg_data_o | output | DW | Message write data |
| msg_ready_i | input | 1 | Message request accepted |

## Verification
A status bit stuck at the wrong value shows on `status_o` one edge after the fire or clear that should have set or cleared it. It also shows on `irq_o` in the same cycle for level channels. If the enable-history registers are wrong, a re-delivery will be missing, or an unwanted one will appear. For lines this is visible one edge after the enable change, and for messages two edges after. If the pending or slot state is wrong, requests are duplicated or dropped, or come out in the wrong order. The bench detects this by counting messages one edge after each acceptance.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned MAX_CH = 32;
  localparam int unsigned IDX_W  = $clog2(MAX_CH);

  // lowest set bit index of a request vector; 0 when empty
  function automatic logic [IDX_W-1:0] lowest_idx(input logic [MAX_CH-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = MAX_CH - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic lvl_i,
  input  logic ch_en_i,
  input  logic msg_en_i,
  input  logic glb_en_i,
  input  logic glb_rise_i,
  input  logic clr_i,
  output logic status_o,
  output logic line_o,
  output logic msg_evt_o
);
  logic status_q, lvl_q, en_q, pulse_q;
  logic active, lvl_drop, redeliver;

  assign active    = ch_en_i & glb_en_i;
  assign lvl_drop  = lvl_q & ~lvl_i;
  assign redeliver = status_q & ((ch_en_i & ~en_q) | glb_rise_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      lvl_q    <= 1'b0;
      en_q     <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      lvl_q   <= lvl_i;
      en_q    <= ch_en_i;
      pulse_q <= fire_i & ~lvl_i & active & ~msg_en_i;
      if (lvl_drop)              status_q <= 1'b0;
      else if (fire_i && lvl_i)  status_q <= 1'b1;
      else if (clr_i)            status_q <= 1'b0;
    end
  end

  assign status_o  = status_q;
  assign line_o    = active & ((lvl_i & ~msg_en_i & status_q) | pulse_q);
  assign msg_evt_o = active & msg_en_i & (fire_i | redeliver);

  p_lvl_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && lvl_i) |=> status_o);
  p_edge_nostat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !lvl_i && !status_o) |=> !status_o);
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(fire_i && lvl_i)) |=> !status_o);
  p_lvl_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q && !lvl_i) |=> !status_o);
endmodule

// File: rtl/tmr_irq_msg_arb.sv
module tmr_irq_msg_arb
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        evt_i,
  input  logic [NCH*(AW+DW)-1:0] route_i,
  input  logic                  ready_i,
  output logic                  valid_o,
  output logic [AW-1:0]         addr_o,
  output logic [DW-1:0]         data_o
);
  localparam int unsigned RW = AW + DW;

  logic [NCH-1:0]   pend_q, grant;
  logic [IDX_W-1:0] sel;
  logic             load, valid_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [RW-1:0]    sel_route;

  assign sel       = lowest_idx(MAX_CH'(pend_q));
  assign load      = (|pend_q) & (~valid_q | ready_i);
  assign grant     = load ? (NCH'(1) << sel) : '0;
  assign sel_route = route_i[sel*RW +: RW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~grant) | evt_i;
      if (load) begin
        valid_q <= 1'b1;
        addr_q  <= sel_route[RW-1:DW];
        data_q  <= sel_route[DW-1:0];
      end else if (ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));
  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pend_q) && !valid_o) |=> valid_o);
  p_grant_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         fire_i,
  input  logic [NCH-1:0]         lvl_i,
  input  logic [NCH-1:0]         ch_en_i,
  input  logic [NCH-1:0]         msg_en_i,
  input  logic                   glb_en_i,
  input  logic [NCH*(AW+DW)-1:0] route_i,
  input  logic                   clr_we_i,
  input  logic [NCH-1:0]         clr_data_i,
  output logic [NCH-1:0]         status_o,
  output logic [NCH-1:0]         irq_o,
  output logic                   msg_valid_o,
  output logic [AW-1:0]          msg_addr_o,
  output logic [DW-1:0]          msg_data_o,
  input  logic                   msg_ready_i
);
  logic           glb_q, glb_rise;
  logic [NCH-1:0] msg_evt, clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glb_q <= 1'b0;
    else        glb_q <= glb_en_i;
  end

  assign glb_rise = glb_en_i & ~glb_q;
  assign clr      = {NCH{clr_we_i}} & clr_data_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_irq_chan u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (fire_i[g]),
      .lvl_i     (lvl_i[g]),
      .ch_en_i   (ch_en_i[g]),
      .msg_en_i  (msg_en_i[g]),
      .glb_en_i  (glb_en_i),
      .glb_rise_i(glb_rise),
      .clr_i     (clr[g]),
      .status_o  (status_o[g]),
      .line_o    (irq_o[g]),
      .msg_evt_o (msg_evt[g])
    );
  end

  tmr_irq_msg_arb #(.NCH(NCH), .AW(AW), .DW(DW)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (msg_evt),
    .route_i(route_i),
    .ready_i(msg_ready_i),
    .valid_o(msg_valid_o),
    .addr_o (msg_addr_o),
    .data_o (msg_data_o)
  );

  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_i |-> (irq_o == '0));
  p_msg_noline_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((msg_en_i & ~$past(msg_en_i)) == '0 && $past(rst_n)) |-> ((irq_o & msg_en_i) == '0));
endmodule

// File: tb/tb_tmr_irq_unit.sv
module tb_tmr_irq_unit;
  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [3:0] fire, lvl, chen;
    logic       glb, clr_we;
    logic [3:0] clr, st, irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{4'b0001, 4'b0001, 4'b0000, 1'b1, 1'b0, 4'b0000, 4'b0001, 4'b0000}, // R1 R3
    '{4'b0000, 4'b0001, 4'b0001, 1'b1, 1'b0, 4'b0000, 4'b0001, 4'b0001}, // R9
    '{4'b0010, 4'b0001, 4'b0011, 1'b1, 1'b0, 4'b0000, 4'b0001, 4'b0011}, // R2
    '{4'b0000, 4'b0001, 4'b0011, 1'b1, 1'b0, 4'b0000, 4'b0001, 4'b0001}, // R2
    '{4'b0000, 4'b0001, 4'b0011, 1'b0, 1'b0, 4'b0000, 4'b0001, 4'b0000}, // R3
    '{4'b0000, 4'b0001, 4'b0011, 1'b1, 1'b0, 4'b0000, 4'b0001, 4'b0001}, // R10
    '{4'b0000, 4'b0001, 4'b0011, 1'b1, 1'b1, 4'b0000, 4'b0001, 4'b0001}, // R8
    '{4'b0000, 4'b0001, 4'b0011, 1'b1, 1'b1, 4'b0001, 4'b0000, 4'b0000}, // R8
    '{4'b0100, 4'b0101, 4'b0111, 1'b1, 1'b0, 4'b0000, 4'b0100, 4'b0100}, // R4
    '{4'b0100, 4'b0101, 4'b0111, 1'b1, 1'b1, 4'b0100, 4'b0100, 4'b0100}, // R8
    '{4'b0000, 4'b0001, 4'b0111, 1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R11
    '{4'b1000, 4'b0001, 4'b0111, 1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0000}  // R3
  };
  localparam string VREQ [NV] = '{"R1","R9","R2","R2","R3","R10","R8","R8","R4","R8","R11","R3"};

  localparam logic [31:0] A0 = 32'hA000_0040, D0 = 32'h0000_0D00;
  localparam logic [31:0] A1 = 32'hA000_0080, D1 = 32'h0000_0D11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] fire_i = '0, lvl_i = '0, ch_en_i = '0, msg_en_i = '0, clr_data_i = '0;
  logic glb_en_i = 1'b0, clr_we_i = 1'b0, msg_ready_i = 1'b0;
  logic [NCH*(AW+DW)-1:0] route_i = '0;
  logic [NCH-1:0] status_o, irq_o;
  logic msg_valid_o;
  logic [AW-1:0] msg_addr_o;
  logic [DW-1:0] msg_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  tmr_irq_unit #(.NCH(NCH), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .fire_i(fire_i), .lvl_i(lvl_i), .ch_en_i(ch_en_i),
    .msg_en_i(msg_en_i), .glb_en_i(glb_en_i), .route_i(route_i), .clr_we_i(clr_we_i),
    .clr_data_i(clr_data_i), .status_o(status_o), .irq_o(irq_o),
    .msg_valid_o(msg_valid_o), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o),
    .msg_ready_i(msg_ready_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    route_i[63:0]   = {A0, D0};
    route_i[127:64] = {A1, D1};
    route_i[191:128] = {32'hA000_00C0, 32'h0000_0D22};
    route_i[255:192] = {32'hA000_0100, 32'h0000_0D33};
    repeat (3) @(negedge clk);
    chk("R3 reset irq", 32'(irq_o), 0);
    chk("R1 reset status", 32'(status_o), 0);
    chk("R5 reset valid", 32'(msg_valid_o), 0);
    rst_n = 1'b1;
    step();

    for (int v = 0; v < NV; v++) begin
      fire_i = VEC[v].fire; lvl_i = VEC[v].lvl; ch_en_i = VEC[v].chen;
      glb_en_i = VEC[v].glb; clr_we_i = VEC[v].clr_we; clr_data_i = VEC[v].clr;
      step();
      chk({VREQ[v], " status"}, 32'(status_o), 32'(VEC[v].st));
      chk({VREQ[v], " irq"}, 32'(irq_o), 32'(VEC[v].irq));
    end
    fire_i = '0; clr_we_i = 1'b0; clr_data_i = '0;

    // message path, edge channels 0 and 1
    msg_en_i = 4'b0011; lvl_i = '0; ch_en_i = 4'b0011; glb_en_i = 1'b1;
    step(); step();
    fire_i = 4'b0011;
    step();
    fire_i = '0;
    chk("R5 no line", 32'(irq_o), 0);
    step();
    chk("R5 valid", 32'(msg_valid_o), 1);
    chk("R12 first addr", msg_addr_o, A0);
    chk("R5 data", msg_data_o, D0);
    step(); step();
    chk("R6 hold valid", 32'(msg_valid_o), 1);
    chk("R6 hold addr", msg_addr_o, A0);
    fire_i = 4'b0010;
    step();
    fire_i = '0;
    msg_ready_i = 1'b1;
    step();
    chk("R12 second addr", msg_addr_o, A1);
    chk("R12 second data", msg_data_o, D1);
    step();
    chk("R7 merged single", 32'(msg_valid_o), 0);
    msg_ready_i = 1'b0;

    // level channel 0 via message: latch while disabled, then re-deliver
    lvl_i = 4'b0001; ch_en_i = 4'b0010; fire_i = 4'b0001;
    step();
    fire_i = '0;
    chk("R1 latched off", 32'(status_o[0]), 1);
    step();
    chk("R3 no msg off", 32'(msg_valid_o), 0);
    ch_en_i = 4'b0011;
    step(); step();
    chk("R9 redeliver", 32'(msg_valid_o), 1);
    chk("R9 addr", msg_addr_o, A0);
    msg_ready_i = 1'b1;
    step();
    msg_ready_i = 1'b0;
    chk("R9 single", 32'(msg_valid_o), 0);
    glb_en_i = 1'b0;
    step();
    glb_en_i = 1'b1;
    step(); step();
    chk("R10 redeliver", 32'(msg_valid_o), 1);
    chk("R10 data", msg_data_o, D0);
    msg_ready_i = 1'b1;
    step();
    msg_ready_i = 1'b0;
    chk("R10 single", 32'(msg_valid_o), 0);

    done = 1'b1;
    finish_run();
  end
endmodule